// File: doc/BRIEF.md
# Dual-Role Byte Serial Port

This block moves one byte each way over a four-wire synchronous serial link. A single 8-bit shift register holds the outgoing byte before a transfer and the incoming byte after it. When the unit is the clock owner it pulls its select output low, produces a run of clock pulses from a programmable divider of the system clock, and exchanges the byte with the far end. When it is not the clock owner it waits for its select input to go low and shifts on the clock supplied from outside.

Software reaches the unit through three registers: a control register, a status register and a data register. Writing the data register while the unit is idle loads the shift register and, in the clock-owner role, starts the exchange at once. Completion raises a flag that can request an interrupt. A data write that arrives during an exchange is refused and recorded in a second flag. If the select input is pulled low by another device while the unit owns the clock, the unit gives up the clock role and reports it through the completion flag.

Top module: `spi_unit`

## Requirements
- R1: In clock-owner role, writing the data register while idle sends the written byte on `mosi_o` and, when the exchange ends, the data register (`reg_sel` 2) reads back the byte received on `miso_i`.
- R2: `sel_n_o` is high while idle, goes low in the cycle after the starting data write, stays low for 17 half-periods (16 clock edges plus one trailing half-period) and then returns high; it is only low while `mosi_oe` is high.
- R3: Control bit 5 chooses bit order: 0 sends and receives the most significant bit first, 1 the least significant bit first, in both directions.
- R4: Control bits 1:0 choose the half-period of the generated clock: 0 gives 2, 1 gives 8, 2 gives 32, 3 gives 64 system clock cycles.
- R5: Status bit 0 (read/write) halves that half-period, so the fastest generated clock is the system clock divided by 2.
- R6: Control bit 3 sets the idle clock level; control bit 2 set to 0 samples on the leading edge and changes data on the trailing edge, set to 1 changes data on the leading edge and samples on the trailing edge.
- R7: Status bit 7 is set when a byte exchange ends; `irq` is high while that bit and control bit 7 are both set.
- R8: A data write during an exchange sets status bit 6, leaves the byte in flight unchanged and does not restart the exchange.
- R9: Status bits 7 and 6 clear only when a status read that saw either of them set is followed by a data register read or write; a data access without that status read leaves them set.
- R10: With control bit 6 set and bit 4 clear the unit shifts on `sck_i`/`mosi_i` only while `ss_n_i` is low, drives `miso_o` with `miso_oe` high only then, and restarts its bit count when `ss_n_i` goes high.
- R11: With control bits 6 and 4 set, a low level on `ss_n_i` clears control bit 4, stops any exchange and sets status bit 7.
- R12: After reset the control and status registers read 0, `sel_n_o` is high and no output enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `reg_sel`, combinational |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an outside clock owner |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for `sck_o` |
| mosi_i | input | 1 | Serial data in when not clock owner |
| mosi_o | output | 1 | Serial data out when clock owner |
| mosi_oe | output | 1 | Drive enable for `mosi_o` |
| miso_i | input | 1 | Serial data in when clock owner |
| miso_o | output | 1 | Serial data out when not clock owner |
| miso_oe | output | 1 | Drive enable for `miso_o` |
| ss_n_i | input | 1 | Select input, active low |
| sel_n_o | output | 1 | Select output to the far device, active low |

## Verification
Register reads are combinational, so the bench samples `rdata` in the same cycle it raises `rd_en`, while flag arming and clearing take effect at the following edge. In the clock-owner role the select output falls one cycle after the data write, the completion flag is set one cycle after the last sampling edge, and select rises one half-period after the sixteenth clock edge; the bench therefore waits for select to rise before reading status or data, and measures the gap between the last two clock edges to check the divider. In the other role every outside pin passes two synchronizer stages and an edge detector, so the outgoing bit changes about three cycles after a clock edge; the bench uses eight-cycle half-periods and samples `miso_o` just before each sampling edge.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 7;
  localparam int EDGES  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } addr_e;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // half-period in system cycles minus one
  function automatic logic [DIV_W-1:0] half_limit(input logic [1:0] rate, input logic dbl);
    logic [2:0] e;
    case (rate)
      2'd0:    e = 3'd1;
      2'd1:    e = 3'd3;
      2'd2:    e = 3'd5;
      default: e = 3'd6;
    endcase
    e = e - {2'b00, dbl};
    return DIV_W'((32'd1 << e) - 32'd1);
  endfunction

  function automatic logic [BYTE_W-1:0] flip(input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = d[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIV_W = 7,
  parameter int EDGES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DIV_W-1:0] lim,
  output logic             run,
  output logic             lvl,
  output logic             edge_stb,
  output logic             edge_lead
);
  localparam int EC_W = $clog2(EDGES + 1);

  logic             run_q, run_d, lvl_q, lvl_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [EC_W-1:0]  ec_q, ec_d;
  logic             tick, last;

  assign tick      = run_q && (cnt_q == lim);
  assign last      = (ec_q == EC_W'(EDGES));
  assign edge_stb  = tick && !last;
  assign edge_lead = ~lvl_q;

  always_comb begin
    run_d = run_q;
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    ec_d  = ec_q;
    if (start) begin
      run_d = 1'b1;
      lvl_d = 1'b0;
      cnt_d = '0;
      ec_d  = '0;
    end else if (abort) begin
      run_d = 1'b0;
      lvl_d = 1'b0;
    end else if (run_q) begin
      if (tick) begin
        cnt_d = '0;
        if (last) begin
          run_d = 1'b0;
        end else begin
          ec_d  = ec_q + 1'b1;
          lvl_d = ~lvl_q;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
      ec_q  <= '0;
    end else begin
      run_q <= run_d;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
      ec_q  <= ec_d;
    end
  end

  assign run = run_q;
  assign lvl = lvl_q;
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         prime,
  input  logic         edge_stb,
  input  logic         edge_lead,
  input  logic         cpha,
  input  logic         sin,
  output logic         sout,
  output logic         done,
  output logic [W-1:0] rx_val
);
  localparam int BC_W = $clog2(W);

  logic [W-1:0]    sr_q, sr_d;
  logic [BC_W-1:0] bc_q, bc_d;
  logic            ob_q, ob_d;
  logic            sample, launch;

  assign sample = edge_stb && (edge_lead ^ cpha);
  assign launch = edge_stb && !(edge_lead ^ cpha);
  assign rx_val = {sr_q[W-2:0], sin};
  assign done   = sample && (bc_q == BC_W'(W - 1));

  always_comb begin
    sr_d = sr_q;
    bc_d = bc_q;
    ob_d = ob_q;
    if (load) begin
      sr_d = load_val;
      bc_d = '0;
      ob_d = load_val[W-1];
    end else if (clr) begin
      bc_d = '0;
    end else if (prime) begin
      bc_d = '0;
      ob_d = sr_q[W-1];
    end else begin
      if (sample) begin
        sr_d = rx_val;
        bc_d = bc_q + 1'b1;
      end
      if (launch) ob_d = sr_q[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      bc_q <= '0;
      ob_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      bc_q <= bc_d;
      ob_q <= ob_d;
    end
  end

  assign sout = ob_q;
endmodule

// File: rtl/spi_unit.sv
module spi_unit
  import spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i,
  output logic       sel_n_o
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // outside pins into the clock domain
  logic ss_s, sck_s, mosi_s, sck_d_q, ss_d_q;
  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({ss_n_i, sck_i, mosi_i}), .q({ss_s, sck_s, mosi_s})
  );
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sck_d_q <= 1'b0;
      ss_d_q  <= 1'b1;
    end else begin
      sck_d_q <= sck_s;
      ss_d_q  <= ss_s;
    end
  end

  ctrl_t      ctrl_q, ctrl_d;
  logic       dbl_q, dbl_d, done_q, done_d, wcol_q, wcol_d, armed_q, armed_d;
  logic [7:0] rx_q, rx_d;

  logic cfg_cpol, cfg_master, is_master, slave_act, fault, busy;
  logic wr_data, data_acc, stat_rd, start, load, collide;
  logic g_run, g_lvl, g_edge, g_lead, s_edge, s_lead;
  logic edge_stb, edge_lead, sin, sout, sh_done, prime, clr;
  logic [7:0] rx_val, load_val;
  logic [DIV_W-1:0] lim;

  assign cfg_cpol   = ctrl_q.cpol;
  assign cfg_master = ctrl_q.master;
  assign is_master  = ctrl_q.enable & cfg_master;
  assign slave_act  = ctrl_q.enable & ~cfg_master & ~ss_s;
  assign fault      = is_master & ~ss_s;
  assign busy       = g_run | slave_act;

  assign wr_data  = wr_en && (reg_sel == ADDR_DATA);
  assign data_acc = (wr_en || rd_en) && (reg_sel == ADDR_DATA);
  assign stat_rd  = rd_en && (reg_sel == ADDR_STAT);
  assign load     = wr_data && !busy;
  assign start    = load && is_master && !fault;
  assign collide  = wr_data && busy;
  assign load_val = ctrl_q.lsb_first ? flip(wdata) : wdata;
  assign lim      = half_limit(ctrl_q.rate, dbl_q);

  spi_clkgen #(.DIV_W(DIV_W), .EDGES(EDGES)) u_clkgen (
    .clk(clk), .rst_n(rst_int_n), .start(start), .abort(fault), .lim(lim),
    .run(g_run), .lvl(g_lvl), .edge_stb(g_edge), .edge_lead(g_lead)
  );

  assign s_edge    = slave_act && (sck_s != sck_d_q);
  assign s_lead    = (sck_s != cfg_cpol);
  assign edge_stb  = is_master ? g_edge : s_edge;
  assign edge_lead = is_master ? g_lead : s_lead;
  assign sin       = is_master ? miso_i : mosi_s;
  assign clr       = ~is_master & ss_s;
  assign prime     = ~is_master & ~ss_s & ss_d_q;

  spi_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load(load), .load_val(load_val),
    .clr(clr), .prime(prime), .edge_stb(edge_stb), .edge_lead(edge_lead),
    .cpha(ctrl_q.cpha), .sin(sin), .sout(sout), .done(sh_done), .rx_val(rx_val)
  );

  // register next state
  always_comb begin
    ctrl_d  = ctrl_q;
    dbl_d   = dbl_q;
    done_d  = done_q;
    wcol_d  = wcol_q;
    armed_d = armed_q;
    rx_d    = rx_q;
    if (wr_en && reg_sel == ADDR_CTRL) ctrl_d = ctrl_t'(wdata);
    if (wr_en && reg_sel == ADDR_STAT) dbl_d = wdata[0];
    if (fault) ctrl_d.master = 1'b0;
    if (stat_rd && (done_q || wcol_q)) armed_d = 1'b1;
    if (data_acc && armed_q) begin
      done_d  = 1'b0;
      wcol_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (sh_done) rx_d = ctrl_q.lsb_first ? flip(rx_val) : rx_val;
    if (sh_done || fault) done_d = 1'b1;
    if (collide) wcol_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= '0;
      dbl_q   <= 1'b0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      dbl_q   <= dbl_d;
      done_q  <= done_d;
      wcol_q  <= wcol_d;
      armed_q <= armed_d;
      rx_q    <= rx_d;
    end
  end

  always_comb begin
    case (reg_sel)
      ADDR_CTRL: rdata = ctrl_q;
      ADDR_STAT: rdata = {done_q, wcol_q, 5'b00000, dbl_q};
      ADDR_DATA: rdata = rx_q;
      default:   rdata = '0;
    endcase
  end

  assign irq     = done_q & ctrl_q.irq_en;
  assign sel_n_o = ~g_run;
  assign sck_o   = cfg_cpol ^ g_lvl;
  assign sck_oe  = is_master;
  assign mosi_o  = sout;
  assign mosi_oe = is_master;
  assign miso_o  = sout;
  assign miso_oe = slave_act;
endmodule

// File: rtl/spi_unit_chk.sv
module spi_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       mosi_oe,
  input logic       miso_oe,
  input logic       sel_n_o,
  input logic       cpol,
  input logic       master,
  input logic       done,
  input logic       wcol,
  input logic       busy,
  input logic       ss_s
);
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_o |-> (sck_o == cpol));

  // R2
  select_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n_o |-> mosi_oe);

  // R10
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !sck_oe);

  // R8
  collision_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(wr_en && reg_sel == 2'd2 && busy));

  // R9
  done_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past((wr_en || rd_en) && reg_sel == 2'd2));

  // R11
  role_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master) |-> ($past(!ss_s) || $past(wr_en && reg_sel == 2'd0)));
endmodule

bind spi_unit spi_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
  .sck_o(sck_o), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
  .sel_n_o(sel_n_o), .cpol(cfg_cpol), .master(cfg_master), .done(done_q),
  .wcol(wcol_q), .busy(busy), .ss_s(ss_s)
);

// File: tb/spi_unit_tb.sv
`timescale 1ns/1ps
module spi_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, sel_n_o;
  logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i),
    .sel_n_o(sel_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = d[i];
    return r;
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // far-end model for clock-owner runs, and clock-period probe
  logic [7:0] exp_q[$];
  logic       m_cpol = 1'b0, m_cpha = 1'b0;
  logic [7:0] far_tx = 8'h00, tx_sh = 8'h00, rx_sh = 8'h00;
  int         nrx = 0;
  longint     t_prev = 0, gap_ns = 0;
  bit         t_valid = 0;
  event       far_done;

  always @(negedge sel_n_o) begin
    tx_sh = far_tx; miso_i = far_tx[7]; nrx = 0; rx_sh = 8'h00; t_valid = 0;
  end

  always @(sck_o) begin
    if (!sel_n_o && sck_oe) begin
      if (t_valid) gap_ns = $time - t_prev;
      t_prev = $time; t_valid = 1;
      if ((sck_o != m_cpol) ^ m_cpha) begin
        rx_sh = {rx_sh[6:0], mosi_o};
        tx_sh = {tx_sh[6:0], 1'b0};
        nrx++;
        if (nrx == 8) -> far_done;
      end else begin
        miso_i = tx_sh[7];
      end
    end
  end

  // monitor: pops the expected wire byte when the far end has eight bits
  initial begin
    forever begin
      @(far_done);
      if (exp_q.size() == 0) chk("R1 unexpected exchange", 32'(rx_sh), 32'hFFFF_FFFF);
      else chk("R1 R3 R8 byte seen on mosi", 32'(rx_sh), 32'(exp_q.pop_front()));
    end
  end

  // driver: one clock-owner exchange
  task automatic run_xfer(input logic [7:0] ctrlv, input logic dblv, input logic [7:0] mtx,
                          input logic [7:0] far_byte, input int half, input bit collide);
    logic [7:0] s, d;
    logic lsb;
    lsb = ctrlv[5];
    m_cpol = ctrlv[3]; m_cpha = ctrlv[2]; far_tx = far_byte;
    reg_wr(2'd1, {7'b0, dblv});
    reg_wr(2'd0, ctrlv);
    chk("R6 idle clock level", 32'(sck_o), 32'(ctrlv[3]));
    chk("R2 select high when idle", 32'(sel_n_o), 32'd1);
    exp_q.push_back(lsb ? rev8(mtx) : mtx);
    reg_wr(2'd2, mtx);
    chk("R2 select low after start", 32'(sel_n_o), 32'd0);
    if (collide) begin
      repeat (10) @(negedge clk);
      reg_wr(2'd2, ~mtx);
    end
    while (!sel_n_o) @(negedge clk);
    chk("R4 R5 half period ns", 32'(gap_ns), 32'(half * 4));
    reg_rd(2'd1, s);
    chk("R7 completion flag", 32'(s[7]), 32'd1);
    chk("R8 collision flag", 32'(s[6]), 32'(collide));
    if (ctrlv[7]) chk("R7 irq raised", 32'(irq), 32'd1);
    reg_rd(2'd2, d);
    chk("R1 R3 R6 received byte", 32'(d), 32'(lsb ? rev8(far_byte) : far_byte));
    reg_rd(2'd1, s);
    chk("R9 flags cleared", 32'(s[7:6]), 32'd0);
    chk("R7 irq cleared", 32'(irq), 32'd0);
  endtask

  initial begin
    logic [7:0] v, got;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    reg_rd(2'd0, v); chk("R12 control after reset", 32'(v), 32'd0);
    reg_rd(2'd1, v); chk("R12 status after reset", 32'(v), 32'd0);
    chk("R12 select high", 32'(sel_n_o), 32'd1);
    chk("R12 no drivers", 32'({sck_oe, mosi_oe, miso_oe, irq}), 32'd0);

    // control: [7] irq_en [6] enable [5] lsb [4] master [3] cpol [2] cpha [1:0] rate
    run_xfer(8'b0101_0000, 1'b0, 8'hA5, 8'h3C, 2, 1'b0);   // R1 R4 mode 0, rate 0
    run_xfer(8'b1101_0101, 1'b1, 8'h5E, 8'hC3, 4, 1'b0);   // R5 R7 mode 1, rate 1 doubled
    run_xfer(8'b0111_1000, 1'b1, 8'h81, 8'h17, 1, 1'b0);   // R3 R5 mode 2, lsb first, fastest
    run_xfer(8'b0101_1111, 1'b0, 8'h69, 8'hE2, 64, 1'b0);  // R4 R6 mode 3, rate 3
    run_xfer(8'b0111_0110, 1'b1, 8'h2D, 8'h90, 16, 1'b0);  // R3 R5 rate 2 doubled
    run_xfer(8'b0101_0011, 1'b0, 8'hC8, 8'h4F, 64, 1'b1);  // R8 write during exchange

    // R9: data access without prior status read leaves the flag set
    m_cpol = 1'b0; m_cpha = 1'b0; far_tx = 8'h77;
    exp_q.push_back(8'h12);
    reg_wr(2'd0, 8'b0101_0000);
    reg_wr(2'd2, 8'h12);
    while (!sel_n_o) @(negedge clk);
    reg_rd(2'd2, v); chk("R1 received byte", 32'(v), 32'h77);
    reg_rd(2'd1, v); chk("R9 flag kept without status read", 32'(v[7]), 32'd1);
    reg_rd(2'd2, v);
    reg_rd(2'd1, v); chk("R9 flag cleared after sequence", 32'(v[7]), 32'd0);

    // R10 outside clock owner, mode 0, msb first
    reg_wr(2'd0, 8'b0100_0000);
    reg_wr(2'd2, 8'h96);
    repeat (4) @(negedge clk);
    chk("R10 miso released while deselected", 32'(miso_oe), 32'd0);
    ss_n_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 miso driven while selected", 32'(miso_oe), 32'd1);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      mosi_i = 8'h4B >> i;
      repeat (8) @(negedge clk);
      got[i] = miso_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R10 byte on miso", 32'(got), 32'h96);
    reg_wr(2'd2, 8'h11);   // refused: still selected
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 miso released after deselect", 32'(miso_oe), 32'd0);
    reg_rd(2'd1, v); chk("R7 R8 status after slave byte", 32'(v[7:6]), 32'd3);
    reg_rd(2'd2, v); chk("R10 received from mosi", 32'(v), 32'h4B);

    // R11 select pulled low while owning the clock
    reg_wr(2'd0, 8'b0101_0000);
    reg_rd(2'd1, v); reg_rd(2'd2, v);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    reg_rd(2'd0, v); chk("R11 role bit cleared", 32'(v), 32'b0100_0000);
    reg_rd(2'd1, v); chk("R11 completion flag on fault", 32'(v[7]), 32'd1);
    chk("R11 clock driver released", 32'(sck_oe), 32'd0);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 no stray exchanges", 32'(exp_q.size()), 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule